// File: doc/BRIEF.md
# Mesh Router Input Port with Dimension-Ordered Steering

This block is one input port of a five-way router in an 8x8 two-dimensional mesh. It pulls 32-bit flits from the upstream neighbour's output queue into a four-entry local queue. It reads the destination column and row from the first flit of each packet and resolves the column offset before the row offset. It then raises exactly one of five output requests (local, north, south, east, west) for every flit of that packet. The node's own column and row are static inputs.

A packet is a fixed eight flits (32 bytes). The route is decided when the header flit leaves the queue and is kept until the eighth flit leaves. A flit leaves only when the output it requests is granted. Arbitration between ports happens outside this block.

Top module: `mesh_in_port`

## Requirements
- R1: The destination column is taken from bits [31:29] of the header flit and the destination row from bits [28:26]. `out_req` is one-hot or zero, with bit 0 = local, bit 1 = north, bit 2 = south, bit 3 = east and bit 4 = west.
- R2: When the destination column differs from `node_x`, the flit requests east if the column is larger and west if it is smaller. The row is not considered in this case.
- R3: When the columns match and the destination row differs from `node_y`, the flit requests north if the row is larger and south if it is smaller.
- R4: When the destination column and row both equal the node's own, the flit requests local.
- R5: `up_rd_en` is high exactly when `up_empty` is low and the local queue holds fewer than 4 flits. A full queue refuses a word even in a cycle where it also releases one. A word is taken from `up_data` in the cycle `up_rd_en` is high.
- R6: Every accepted word appears on `out_data` exactly once, in arrival order.
- R7: A flit leaves only when the queue is non-empty and the grant bit matching its request is high. A grant on any other output is ignored, and the flit and its request stay unchanged.
- R8: Flits 2 to 8 of a packet carry the header's route, whatever their own bits [31:26] hold.
- R9: After the eighth flit leaves, the next flit is treated as a header and its route is computed afresh.
- R10: `out_req` is all zero while the local queue is empty.
- R11: A synchronous active-high `rst` empties the queue, restarts the flit count at the header and drops the held route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_x | input | 3 | Own column coordinate |
| node_y | input | 3 | Own row coordinate |
| up_data | input | 32 | Head word of the upstream output queue |
| up_empty | input | 1 | Upstream output queue is empty |
| up_rd_en | output | 1 | Takes the upstream head word this cycle |
| out_data | output | 32 | Flit at the head of the local queue |
| out_req | output | 5 | One-hot output request |
| out_grant | input | 5 | Grant per output, same bit order as out_req |

## Verification
Two things can happen in the same cycle: accepting a word from upstream and releasing a flit downstream. The bench provokes this with random grant patterns while the upstream queue stays busy. In each such cycle it judges that the occupancy it tracks is unchanged and that data still arrives in order. It also stalls the outputs until the queue is full and then grants. In that cycle a release happens while a new word is refused, so `up_rd_en` must be low even though a slot is freeing. Header release coinciding with an incoming word is checked by the route expected for each following flit.

// File: rtl/mesh_pkg.sv
package mesh_pkg;
  localparam int COORD_W    = 3;
  localparam int FLIT_W     = 32;
  localparam int PKT_FLITS  = 8;
  localparam int QUEUE_SLOTS = 4;
  localparam int NUM_DIRS   = 5;

  typedef enum logic [2:0] {
    DIR_LOCAL = 3'd0,
    DIR_NORTH = 3'd1,
    DIR_SOUTH = 3'd2,
    DIR_EAST  = 3'd3,
    DIR_WEST  = 3'd4
  } dir_e;

  // Column offset first, row offset only once the column matches.
  function automatic dir_e xy_pick(input logic [COORD_W-1:0] dst_x,
                                   input logic [COORD_W-1:0] dst_y,
                                   input logic [COORD_W-1:0] own_x,
                                   input logic [COORD_W-1:0] own_y);
    if (dst_x > own_x)      return DIR_EAST;
    else if (dst_x < own_x) return DIR_WEST;
    else if (dst_y > own_y) return DIR_NORTH;
    else if (dst_y < own_y) return DIR_SOUTH;
    else                    return DIR_LOCAL;
  endfunction

  function automatic logic [NUM_DIRS-1:0] dir_onehot(input dir_e d);
    logic [NUM_DIRS-1:0] v;
    v = '0;
    v[d] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/flit_fifo.sv
module flit_fifo #(
  parameter int W     = mesh_pkg::FLIT_W,
  parameter int DEPTH = mesh_pkg::QUEUE_SLOTS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    slots [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;

  assign full  = (count == CNTW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = slots[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (count == '0));
endmodule

// File: rtl/route_hold.sv
module route_hold
  import mesh_pkg::*;
#(
  parameter int FW  = FLIT_W,
  parameter int CW  = COORD_W,
  parameter int PKT = PKT_FLITS,
  parameter int ND  = NUM_DIRS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] own_x,
  input  logic [CW-1:0] own_y,
  input  logic [FW-1:0] head,
  input  logic          head_valid,
  input  logic [ND-1:0] grant,
  output logic [ND-1:0] req,
  output logic          pop
);
  localparam int NW = (PKT > 1) ? $clog2(PKT) : 1;

  logic [NW-1:0] flit_idx;
  dir_e          held_dir, cur_dir;
  logic          at_header, at_tail;
  logic [CW-1:0] dst_x, dst_y;

  assign at_header = (flit_idx == '0);
  assign at_tail   = (flit_idx == NW'(PKT - 1));
  assign dst_x     = head[FW-1 -: CW];
  assign dst_y     = head[FW-1-CW -: CW];
  assign cur_dir   = at_header ? xy_pick(dst_x, dst_y, own_x, own_y) : held_dir;
  assign req       = head_valid ? dir_onehot(cur_dir) : '0;
  assign pop       = |(req & grant);

  always_ff @(posedge clk) begin
    if (rst) begin
      flit_idx <= '0;
      held_dir <= DIR_LOCAL;
    end else if (pop) begin
      flit_idx <= at_tail ? '0 : flit_idx + 1'b1;
      if (at_header) held_dir <= cur_dir;
    end
  end

  a_r8_route_held: assert property (@(posedge clk) disable iff (rst)
    (pop && !at_tail) |=> (req == '0 || req == $past(req)));
  a_r7_stall_keeps_req: assert property (@(posedge clk) disable iff (rst)
    (req != '0 && !pop) |=> (req == $past(req)));
endmodule

// File: rtl/mesh_in_port.sv
module mesh_in_port
  import mesh_pkg::*;
#(
  parameter int FW    = FLIT_W,
  parameter int CW    = COORD_W,
  parameter int PKT   = PKT_FLITS,
  parameter int DEPTH = QUEUE_SLOTS,
  parameter int ND    = NUM_DIRS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] node_x,
  input  logic [CW-1:0] node_y,
  input  logic [FW-1:0] up_data,
  input  logic          up_empty,
  output logic          up_rd_en,
  output logic [FW-1:0] out_data,
  output logic [ND-1:0] out_req,
  input  logic [ND-1:0] out_grant
);
  logic q_full, q_empty, q_pop, accept;

  // Take a word only when one is offered and a slot is free now.
  assign accept   = !up_empty && !q_full;
  assign up_rd_en = accept;

  flit_fifo #(.W(FW), .DEPTH(DEPTH)) u_queue (
    .clk   (clk),
    .rst   (rst),
    .push  (accept),
    .din   (up_data),
    .pop   (q_pop),
    .dout  (out_data),
    .full  (q_full),
    .empty (q_empty)
  );

  route_hold #(.FW(FW), .CW(CW), .PKT(PKT), .ND(ND)) u_route (
    .clk        (clk),
    .rst        (rst),
    .own_x      (node_x),
    .own_y      (node_y),
    .head       (out_data),
    .head_valid (!q_empty),
    .grant      (out_grant),
    .req        (out_req),
    .pop        (q_pop)
  );

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    q_empty |-> (out_req == '0));
  a_r1_onehot_req: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_req));
endmodule

// File: tb/test_mesh_in_port.sv
`timescale 1ns/1ps
module test_mesh_in_port;
  localparam int SLOTS = 4;
  localparam logic [2:0] MY_X = 3'd3;
  localparam logic [2:0] MY_Y = 3'd4;

  typedef struct {
    logic [31:0] w;
    logic [4:0]  r;
    string       tag;
  } item_t;

  logic        clk = 0, rst = 1;
  logic [31:0] up_data = '0;
  logic        up_empty = 1;
  logic        up_rd_en;
  logic [31:0] out_data;
  logic [4:0]  out_req, out_grant = '0;

  int checks = 0, fails = 0;
  bit run = 0, done = 0;
  int gmode = 0;
  int pkt_count = 0;
  item_t src_q[$];
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  mesh_in_port i_mesh_in_port (
    .clk(clk), .rst(rst), .node_x(MY_X), .node_y(MY_Y),
    .up_data(up_data), .up_empty(up_empty), .up_rd_en(up_rd_en),
    .out_data(out_data), .out_req(out_req), .out_grant(out_grant)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Reference steering, written as offsets rather than a priority chain.
  function automatic logic [4:0] ref_route(input logic [2:0] dx, input logic [2:0] dy);
    int ox, oy;
    ox = int'(dx) - int'(MY_X);
    oy = int'(dy) - int'(MY_Y);
    if (ox > 0) return 5'b01000;
    if (ox < 0) return 5'b10000;
    if (oy > 0) return 5'b00010;
    if (oy < 0) return 5'b00100;
    return 5'b00001;
  endfunction

  // Driver: push one 8-flit packet into the upstream model and the expectations.
  task automatic send_packet(input logic [2:0] dx, input logic [2:0] dy);
    item_t it;
    logic [4:0] r;
    string t;
    r = ref_route(dx, dy);
    if (dx != MY_X)      t = "R1/R2";
    else if (dy != MY_Y) t = "R1/R3";
    else                 t = "R1/R4";
    if (pkt_count > 0) t = {t, "/R9"};
    pkt_count++;
    for (int k = 0; k < 8; k++) begin
      it.w   = (k == 0) ? {dx, dy, 26'($urandom())} : $urandom();
      it.r   = r;
      it.tag = (k == 0) ? t : "R8";
      src_q.push_back(it);
    end
  endtask

  task automatic drain();
    while (src_q.size() != 0 || exp_q.size() != 0) @(negedge clk);
    #2;
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      up_empty = (src_q.size() == 0);
      up_data  = up_empty ? 32'h0 : src_q[0].w;
      begin
        logic [4:0] e_req;
        e_req = (exp_q.size() != 0) ? exp_q[0].r : 5'b0;
        case (gmode)
          0: out_grant = 5'h1f;
          1: out_grant = 5'h00;
          2: out_grant = 5'($urandom());
          default: out_grant = ~e_req;
        endcase
        #1;
        if (run && !rst) begin
          int occ;
          bit e_rd;
          occ = exp_q.size();
          if (exp_q.size() == 0)
            chk(out_req == 5'b0, "R10", {27'b0, out_req}, 32'h0);
          else
            chk(out_req == e_req, exp_q[0].tag, {27'b0, out_req}, {27'b0, e_req});
          if (|(e_req & out_grant)) begin
            chk(out_data == exp_q[0].w, "R6", out_data, exp_q[0].w);
            void'(exp_q.pop_front());
          end else if (e_req != 0 && out_grant != 0) begin
            chk(out_req == e_req, "R7", {27'b0, out_req}, {27'b0, e_req});
          end
          e_rd = (src_q.size() != 0) && (occ < SLOTS);
          chk(up_rd_en == e_rd, "R5", {31'b0, up_rd_en}, {31'b0, e_rd});
          if (up_rd_en && src_q.size() != 0) exp_q.push_back(src_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk(out_req == 5'b0, "R11", {27'b0, out_req}, 32'h0);
    chk(up_rd_en == 1'b0, "R11", {31'b0, up_rd_en}, 32'h0);
    rst = 0;
    run = 1;

    // Directed destinations, full grants
    gmode = 0;
    send_packet(3'd5, 3'd1);
    send_packet(3'd0, 3'd7);
    send_packet(3'd3, 3'd6);
    send_packet(3'd3, 3'd0);
    send_packet(3'd3, 3'd4);
    send_packet(3'd7, 3'd4);
    drain();

    // Random grants: accept and release collide often
    gmode = 2;
    for (int p = 0; p < 12; p++) send_packet(3'($urandom()), 3'($urandom()));
    drain();

    // Stall until full, then wrong-output grants, then release
    gmode = 1;
    send_packet(3'd1, 3'd2);
    send_packet(3'd3, 3'd5);
    repeat (20) @(negedge clk);
    gmode = 3;
    repeat (10) @(negedge clk);
    gmode = 0;
    drain();

    // Reset in the middle of a packet
    gmode = 1;
    send_packet(3'd6, 3'd6);
    repeat (5) @(negedge clk);
    #2;
    rst = 1;
    src_q.delete();
    exp_q.delete();
    repeat (2) @(negedge clk);
    #2;
    chk(out_req == 5'b0, "R11", {27'b0, out_req}, 32'h0);
    chk(up_rd_en == 1'b0, "R11", {31'b0, up_rd_en}, 32'h0);
    rst = 0;
    pkt_count = 0;
    gmode = 0;
    send_packet(3'd3, 3'd1);
    send_packet(3'd2, 3'd4);
    drain();

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule